// File: doc/BRIEF.md
# Multi-Mode DMA Channel Engine

This block is one channel of a DMA controller. It moves 32-bit words between a word-addressed memory port and a device port. Software programs it through four small registers: a start address, a count word and a control word for the channel, plus an interrupt register that a controller would share across channels. Every memory access uses a valid/ready handshake, so the engine waits through any number of memory or device wait states.

There are four transfer kinds. A single block moves one run of words. A multi-block transfer moves the block size times the block count. A linked-list walk follows headers in memory and sends each header's payload words to the device. An ordering-table clear writes a chain of backward pointers into memory. When a transfer ends, the engine drops its busy bit and can raise an interrupt flag.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, all four registers read zero, `irq` is low and no memory or device handshake is offered.
- R2: Register select 2 is the control word. A transfer starts only when its enable bit 24 is set and either the mode field (bits 10:9) is nonzero or the trigger bit 28 is set. In mode 0, enable without trigger causes no access.
- R3: Register select 0 is the start address. Every memory address equals the running address ANDed with 0x1FFFFC. After each word the address moves down by 4 if control bit 1 is set, and up by 4 otherwise.
- R4: Register select 1 is the count word. Mode 0 moves the count in bits 15:0. Mode 1 moves bits 15:0 times bits 31:16. A zero field stands for 65536. When a mode 1 transfer ends, bits 31:16 are cleared and bits 15:0 are kept.
- R5: In modes 0 and 1, control bit 0 set means each word is read from memory and then offered on the device output. Bit 0 clear means each word is taken from the device input and then written to memory.
- R6: Mode 2 walks a list. Each header read gives a payload length in bits 31:24 and a next pointer in bits 23:0, masked as in R3. The payload words that follow the header are sent to the device. The walk ends after a header with bit 23 set. At the end only bit 24 of the control word is cleared, and the count word is unchanged.
- R7: Mode 3 clears an ordering table. Starting at the start address and moving down, it writes N entries, where N is given as in mode 0. Each entry holds its own address minus 4, ANDed with 0x1FFFFF. The last entry holds 0x00FFFFFF.
- R8: When a mode 0, 1 or 3 transfer ends, control bits 24 and 28 are both cleared.
- R9: Register select 3 is the interrupt register. For channel n (parameter CH_ID), if bit 16+n and master bit 23 are both set when a transfer ends, flag bit 24+n is set and `irq` goes high. Writing 1 to the flag clears it. A flag set and a clear in the same cycle leave the flag set.
- R10: While `mem_valid` waits for `mem_ready`, the address, the direction and the write data hold steady. `dev_out_data` likewise holds while `dev_out_valid` waits.
- R11: While a transfer runs, writes to the start address, to the count word and to every control bit other than bit 24 are ignored. Clearing bit 24 stops the transfer after the current word. The trigger bit is kept and no flag is raised.
- R12: If a control write lands in the cycle a transfer ends, the completion wins: bits 24 and 28 read back cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 count, 2 control, 3 interrupt |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | Request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request; read data is valid |
| mem_rdata | input | 32 | Memory read data |
| dev_out_valid | output | 1 | Word offered to the device |
| dev_out_data | output | 32 | Word to the device |
| dev_out_ready | input | 1 | Device accepts the word |
| dev_in_valid | input | 1 | Device offers a word |
| dev_in_data | input | 32 | Word from the device |
| dev_in_ready | output | 1 | Engine accepts a device word |
| irq | output | 1 | Channel interrupt flag |

## Verification
Two things can land in the cycle where the engine finishes. One is a software write to the control word. The other is a write that clears the interrupt flag. The bench provokes each one by repeating that write every cycle while a short transfer runs. It stops once it sees the busy bit fall, or the flag rise, which leaves exactly one write on the finishing edge. The bench then judges the read-back. Bits 24 and 28 must be cleared, and the flag must still be set. Memory and device stalls are random throughout, and every handshake is compared with the reference model as it happens.

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
  parameter int          CH_ID     = 2,
  parameter logic [31:0] ADDR_MASK = 32'h001F_FFFC,
  parameter logic [31:0] LINK_MASK = 32'h001F_FFFF,
  parameter logic [31:0] TBL_END   = 32'h00FF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_valid,
  output logic        mem_write,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ready,
  input  logic [31:0] mem_rdata,
  output logic        dev_out_valid,
  output logic [31:0] dev_out_data,
  input  logic        dev_out_ready,
  input  logic        dev_in_valid,
  input  logic [31:0] dev_in_data,
  output logic        dev_in_ready,
  output logic        irq
);
  localparam int          EN_BIT   = 16 + CH_ID;
  localparam int          FLAG_BIT = 24 + CH_ID;
  localparam logic [31:0] CTL_MASK = 32'h1100_0603;
  localparam logic [31:0] IEN_MASK = (32'h1 << EN_BIT) | (32'h1 << 23);
  localparam logic [31:0] IFL_MASK = 32'h1 << FLAG_BIT;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_RD, S_PUSH, S_PULL, S_WR} st_t;
  st_t st;

  logic [31:0] base_q, cnt_q, ctl_q, irq_q, addr_q, buf_q;
  logic [23:0] hdr_q;
  logic [32:0] rem_q;
  logic [1:0]  mode_q;
  logic [31:0] ctl_nxt, irq_nxt;
  logic        fin;

  wire        busy   = st != S_IDLE;
  wire [1:0]  mode_w = ctl_q[10:9];
  wire        start  = !busy && ctl_q[24] && (mode_w != 2'd0 || ctl_q[28]);
  wire [16:0] bsz    = cnt_q[15:0]  == 16'd0 ? 17'h10000 : {1'b0, cnt_q[15:0]};
  wire [16:0] bcn    = cnt_q[31:16] == 16'd0 ? 17'h10000 : {1'b0, cnt_q[31:16]};
  wire [32:0] total  = mode_w == 2'd1 ? 33'(bsz) * 33'(bcn) : 33'(bsz);
  wire        dec    = (ctl_q[1] && mode_q != 2'd2) || mode_q == 2'd3;
  wire [31:0] step_addr = (dec ? addr_q - 32'd4 : addr_q + 32'd4) & ADDR_MASK;
  wire        last   = rem_q == 33'd1;
  wire [31:0] tbl_word = last ? TBL_END : (addr_q - 32'd4) & LINK_MASK;
  wire        mem_hs = mem_valid && mem_ready;
  wire        out_hs = dev_out_valid && dev_out_ready;
  wire        in_hs  = dev_in_valid && dev_in_ready;

  assign mem_valid     = st == S_HDR || st == S_RD || st == S_WR;
  assign mem_write     = st == S_WR;
  assign mem_addr      = addr_q;
  assign mem_wdata     = mode_q == 2'd3 ? tbl_word : buf_q;
  assign dev_out_valid = st == S_PUSH;
  assign dev_out_data  = buf_q;
  assign dev_in_ready  = st == S_PULL;
  assign irq           = irq_q[FLAG_BIT];

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = base_q;
      2'd1:    reg_rdata = cnt_q;
      2'd2:    reg_rdata = ctl_q;
      default: reg_rdata = irq_q;
    endcase
  end

  always_comb begin
    case (st)
      S_HDR:   fin = mem_hs && mem_rdata[31:24] == 8'd0 && mem_rdata[23];
      S_PUSH:  fin = out_hs && last && (mode_q != 2'd2 || hdr_q[23]);
      S_WR:    fin = mem_hs && last;
      default: fin = 1'b0;
    endcase
  end

  always_comb begin
    ctl_nxt = ctl_q;
    if (reg_wr && reg_sel == 2'd2) begin
      if (busy) ctl_nxt[24] = reg_wdata[24];
      else      ctl_nxt = reg_wdata & CTL_MASK;
    end
    if (fin) begin
      ctl_nxt[24] = 1'b0;
      if (mode_q != 2'd2) ctl_nxt[28] = 1'b0;
    end
  end

  always_comb begin
    irq_nxt = irq_q;
    if (reg_wr && reg_sel == 2'd3)
      irq_nxt = (reg_wdata & IEN_MASK) | (irq_q & IFL_MASK & ~reg_wdata);
    if (fin && irq_q[EN_BIT] && irq_q[23]) irq_nxt[FLAG_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      ctl_q  <= '0;
      irq_q  <= '0;
    end else begin
      ctl_q <= ctl_nxt;
      irq_q <= irq_nxt;
      if (reg_wr && reg_sel == 2'd0 && !busy) base_q <= reg_wdata;
      if (reg_wr && reg_sel == 2'd1 && !busy) cnt_q  <= reg_wdata;
      if (fin && mode_q == 2'd1) cnt_q[31:16] <= 16'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      mode_q <= 2'd0;
      addr_q <= '0;
      buf_q  <= '0;
      hdr_q  <= '0;
      rem_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          mode_q <= mode_w;
          addr_q <= base_q & ADDR_MASK;
          rem_q  <= total;
          if      (mode_w == 2'd2) st <= S_HDR;
          else if (mode_w == 2'd3) st <= S_WR;
          else if (ctl_q[0])       st <= S_RD;
          else                     st <= S_PULL;
        end
        S_HDR: if (mem_hs) begin
          hdr_q <= mem_rdata[23:0];
          if (mem_rdata[31:24] != 8'd0) begin
            rem_q  <= {25'd0, mem_rdata[31:24]};
            addr_q <= step_addr;
            st     <= S_RD;
          end else if (mem_rdata[23]) begin
            st <= S_IDLE;
          end else begin
            addr_q <= mem_rdata & ADDR_MASK;
          end
        end
        S_RD: if (mem_hs) begin
          buf_q <= mem_rdata;
          st    <= S_PUSH;
        end
        S_PUSH: if (out_hs) begin
          rem_q <= rem_q - 33'd1;
          if (fin) begin
            st <= S_IDLE;
          end else if (mode_q == 2'd2 && last) begin
            addr_q <= {8'd0, hdr_q} & ADDR_MASK;
            st     <= ctl_q[24] ? S_HDR : S_IDLE;
          end else begin
            addr_q <= step_addr;
            st     <= ctl_q[24] ? S_RD : S_IDLE;
          end
        end
        S_PULL: if (in_hs) begin
          buf_q <= dev_in_data;
          st    <= S_WR;
        end
        S_WR: if (mem_hs) begin
          rem_q <= rem_q - 33'd1;
          if (fin || !ctl_q[24]) begin
            st <= S_IDLE;
          end else begin
            addr_q <= step_addr;
            st     <= mode_q == 2'd3 ? S_WR : S_PULL;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_addr_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr & ~ADDR_MASK) == 32'd0);

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata));

  p_dev_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dev_out_valid && !dev_out_ready |=> dev_out_valid && $stable(dev_out_data));

  p_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !(ctl_q[24] && (ctl_q[10:9] != 2'd0 || ctl_q[28])) |=> !mem_valid && !dev_in_ready);

  p_fin_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !ctl_q[24]);

  p_flag_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(irq_q[EN_BIT] && irq_q[23]));

  p_cnt_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fin |=> $stable(cnt_q) && $stable(base_q));
endmodule

// File: tb/dma_chan_engine_bench.sv
module dma_chan_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_valid, mem_write;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        dev_out_valid;
  logic [31:0] dev_out_data;
  logic        dev_out_ready = 1'b0;
  logic        dev_in_valid = 1'b0;
  logic [31:0] dev_in_data = '0;
  logic        dev_in_ready;
  logic        irq;

  dma_chan_engine u_dma_chan_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
    .dev_out_ready(dev_out_ready), .dev_in_valid(dev_in_valid),
    .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready), .irq(irq));

  always #4 clk = ~clk;

  int vecs = 0, errs = 0, seq = 0;
  bit finished = 0;
  string cur_req = "R1";
  logic [31:0] mmod [logic [31:0]];
  logic [31:0] exp_rd[$], exp_wa[$], exp_wd[$], exp_dev[$];

  function automatic logic [31:0] mrd(logic [31:0] a);
    return mmod.exists(a) ? mmod[a] : (32'hC0DE_0000 ^ a);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    mem_ready     = ($urandom_range(3) != 0);
    dev_out_ready = ($urandom_range(2) != 0);
    dev_in_valid  = ($urandom_range(2) != 0);
    dev_in_data   = 32'hD000_0000 + 32'(seq);
    if (mem_valid && mem_ready) begin
      if (!mem_write) begin
        if (exp_rd.size() == 0) chk({cur_req, " unexpected read"}, mem_addr, 32'hFFFF_FFFF);
        else chk({cur_req, " read addr"}, mem_addr, exp_rd.pop_front());
        mem_rdata = mrd(mem_addr);
      end else begin
        if (exp_wa.size() == 0 || exp_wd.size() == 0)
          chk({cur_req, " unexpected write"}, mem_addr, 32'hFFFF_FFFF);
        else begin
          chk({cur_req, " write addr"}, mem_addr, exp_wa.pop_front());
          chk({cur_req, " write data"}, mem_wdata, exp_wd.pop_front());
        end
        mmod[mem_addr] = mem_wdata;
      end
    end
    if (dev_out_valid && dev_out_ready) begin
      if (exp_dev.size() == 0) chk({cur_req, " unexpected device word"}, dev_out_data, 32'hFFFF_FFFF);
      else chk({cur_req, " device word"}, dev_out_data, exp_dev.pop_front());
    end
    if (dev_in_valid && dev_in_ready) begin
      exp_wd.push_back(dev_in_data);
      seq++;
    end
  end

  task automatic wr(logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] s, output logic [31:0] v);
    @(negedge clk);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  task automatic wait_done;
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      rd(2'd2, v);
      if (!v[24]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic queues_empty(string req);
    chk({req, " pending"}, 32'(exp_rd.size() + exp_wa.size() + exp_dev.size()), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic [31:0] v;
    int seen;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int s = 0; s < 4; s++) begin rd(2'(s), v); chk("R1 register", v, 32'd0); end
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 idle bus", {30'd0, mem_valid, dev_out_valid}, 32'd0);

    // R2, R5, R3: mode 0 needs trigger; memory to device, incrementing
    cur_req = "R2";
    wr(2'd0, 32'hA000_0101);
    wr(2'd1, 32'd3);
    wr(2'd2, 32'h0100_0001);
    seen = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); #1 if (mem_valid) seen++; end
    chk("R2 no access without trigger", 32'(seen), 32'd0);
    cur_req = "R5";
    for (int i = 0; i < 3; i++) begin
      exp_rd.push_back(32'h100 + 32'(4 * i));
      exp_dev.push_back(mrd(32'h100 + 32'(4 * i)));
    end
    wr(2'd2, 32'h1100_0001);
    wait_done();
    queues_empty("R5");
    rd(2'd2, v); chk("R8 control after block", v, 32'h0000_0001);
    chk("R9 no irq without enable", {31'd0, irq}, 32'd0);

    // R4, R3, R9: multi-block, device to memory, decrementing, wraps
    cur_req = "R4";
    wr(2'd3, 32'h0084_0000);
    wr(2'd0, 32'h8000_0013);
    wr(2'd1, 32'h0003_0002);
    exp_wa = '{32'h10, 32'hC, 32'h8, 32'h4, 32'h0, 32'h1F_FFFC};
    wr(2'd2, 32'h1100_0202);
    wait_done();
    queues_empty("R4");
    chk("R3 wrapped entry", mmod.exists(32'h1F_FFFC) ? 32'd1 : 32'd0, 32'd1);
    rd(2'd1, v); chk("R4 count upper cleared", v, 32'h0000_0002);
    rd(2'd2, v); chk("R8 control cleared", v, 32'h0000_0202);
    rd(2'd3, v); chk("R9 flag set", v, 32'h0484_0000);
    chk("R9 irq high", {31'd0, irq}, 32'd1);
    wr(2'd3, 32'h0484_0000);
    rd(2'd3, v); chk("R9 flag cleared", v, 32'h0084_0000);
    chk("R9 irq low", {31'd0, irq}, 32'd0);

    // R6 linked list
    cur_req = "R6";
    mmod[32'h200] = {8'd2, 24'h000300};
    mmod[32'h204] = 32'h1111_1111;
    mmod[32'h208] = 32'h2222_2222;
    mmod[32'h300] = {8'd0, 24'h000400};
    mmod[32'h400] = {8'd1, 24'h800123};
    mmod[32'h404] = 32'h3333_3333;
    exp_rd  = '{32'h200, 32'h204, 32'h208, 32'h300, 32'h400, 32'h404};
    exp_dev = '{32'h1111_1111, 32'h2222_2222, 32'h3333_3333};
    wr(2'd0, 32'h200);
    wr(2'd1, 32'h0005_0007);
    wr(2'd2, 32'h1100_0401);
    wait_done();
    queues_empty("R6");
    rd(2'd2, v); chk("R6 trigger kept", v, 32'h1000_0401);
    rd(2'd1, v); chk("R6 count unchanged", v, 32'h0005_0007);
    chk("R9 irq after list", {31'd0, irq}, 32'd1);
    wr(2'd3, 32'h0484_0000);

    // R7 ordering-table clear, plain and across the window bottom
    cur_req = "R7";
    exp_wa = '{32'h1000, 32'hFFC, 32'hFF8, 32'hFF4};
    exp_wd = '{32'hFFC, 32'hFF8, 32'hFF4, 32'h00FF_FFFF};
    wr(2'd0, 32'h1000);
    wr(2'd1, 32'd4);
    wr(2'd2, 32'h0100_0600);
    wait_done();
    queues_empty("R7");
    rd(2'd2, v); chk("R8 control after table", v, 32'h0000_0600);
    exp_wa = '{32'h4, 32'h0, 32'h1F_FFFC};
    exp_wd = '{32'h0, 32'h1F_FFFC, 32'h00FF_FFFF};
    wr(2'd0, 32'h4);
    wr(2'd1, 32'd3);
    wr(2'd2, 32'h0100_0600);
    wait_done();
    queues_empty("R7 wrap");
    wr(2'd3, 32'h0484_0000);
    exp_wd.delete();

    // R11 busy writes ignored, enable clear aborts
    cur_req = "R11";
    for (int i = 0; i < 200; i++) exp_wa.push_back(32'h2000 + 32'(4 * i));
    wr(2'd0, 32'h2000);
    wr(2'd1, 32'd200);
    wr(2'd2, 32'h1100_0000);
    repeat (10) @(negedge clk);
    wr(2'd0, 32'h5000);
    wr(2'd1, 32'd7);
    wr(2'd2, 32'h1100_0603);
    rd(2'd0, v); chk("R11 address frozen", v, 32'h2000);
    rd(2'd1, v); chk("R11 count frozen", v, 32'd200);
    rd(2'd2, v); chk("R11 control frozen", v, 32'h1100_0000);
    wr(2'd2, 32'h0);
    repeat (10) @(negedge clk);
    seen = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); #1 if (mem_valid || dev_in_ready) seen++; end
    chk("R11 stopped", 32'(seen), 32'd0);
    chk("R11 transfer cut short", (exp_wa.size() > 0) ? 32'd1 : 32'd0, 32'd1);
    rd(2'd2, v); chk("R11 trigger kept", v, 32'h1000_0000);
    chk("R11 no flag", {31'd0, irq}, 32'd0);
    exp_wa.delete(); exp_wd.delete();
    wr(2'd2, 32'h0);

    // R12 control write on the finishing edge
    cur_req = "R12";
    exp_wa = '{32'h3000, 32'h3004, 32'h3008};
    wr(2'd0, 32'h3000);
    wr(2'd1, 32'd3);
    wr(2'd2, 32'h1100_0000);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      reg_sel = 2'd2; reg_wdata = 32'h1100_0603; reg_wr = 1'b1;
      #1 if (!reg_rdata[24]) begin reg_wr = 1'b0; break; end
    end
    reg_wr = 1'b0;
    repeat (4) @(negedge clk);
    queues_empty("R12");
    rd(2'd2, v); chk("R12 completion wins", v, 32'h0000_0000);
    chk("R9 flag from R12 run", {31'd0, irq}, 32'd1);
    wr(2'd3, 32'h0484_0000);
    exp_wd.delete();

    // R9 flag clear on the setting edge
    cur_req = "R9";
    exp_wa = '{32'h3100, 32'h3104, 32'h3108};
    wr(2'd0, 32'h3100);
    wr(2'd2, 32'h1100_0000);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      reg_sel = 2'd3; reg_wdata = 32'h0484_0000; reg_wr = 1'b1;
      #1 if (reg_rdata[26]) begin reg_wr = 1'b0; break; end
    end
    reg_wr = 1'b0;
    repeat (4) @(negedge clk);
    queues_empty("R9");
    chk("R9 set beats clear", {31'd0, irq}, 32'd1);
    rd(2'd3, v); chk("R9 register", v, 32'h0484_0000);
    summary();
  end
endmodule